// File: doc/BRIEF.md
# Packet-Driven Firmware Copy Engine

This block moves a firmware image, one byte per cycle, from a small circular staging RAM into an instruction ROM while the system is in download mode. A receive path fills the staging RAM and pulses `pkt_done` once for every complete 64-byte packet. Each pulse starts a burst of 64 staging-RAM reads. Two cycles later the same bytes are written into the ROM at running addresses, so the image builds up in order, packet after packet.

One byte counter drives both sides. Its low 8 bits address the 256-byte staging RAM, and its full width is the ROM write address. The ROM write enable and address are the read enable and counter delayed by two register stages. The write data is the RAM read data, registered once after the RAM's one-cycle read latency. A pulse that arrives during a burst is held as pending, and it starts the next burst in the cycle after the current one ends. Leaving download mode clears the counter, the pending flag and the write pipeline.

The controller has two states. `ST_IDLE` waits for a packet. `ST_COPY` issues one read per cycle. It has these transitions:
- *start*: `ST_IDLE` to `ST_COPY` on a packet pulse in download mode.
- *chain*: `ST_COPY` to `ST_COPY` on the last beat when a packet is pending or arrives in that cycle.
- *finish*: `ST_COPY` to `ST_IDLE` on the last beat when no packet is waiting.
- *abort*: any state to `ST_IDLE` when download mode is low.

Top module: `code_loader`

## Requirements
- R1: After reset, and after every exit from download mode, the byte counter is 0. The first staging read address and the first ROM write address after that point are both 0.
- R2: A `pkt_done` pulse sampled in `ST_IDLE` with `dl_mode` high makes `stg_rd_en` high from the next cycle for exactly 64 consecutive cycles. The counter advances by one in each of those cycles.
- R3: `stg_rd_addr` equals the low 8 bits of the byte counter in the same cycle, with no delay.
- R4: `rom_we` and `rom_waddr` equal `stg_rd_en` and the counter from exactly two cycles earlier.
- R5: `rom_wdata` equals the staging-RAM byte at the address read two cycles earlier. The RAM returns its data one cycle after the read.
- R6: Packets are appended. The first ROM address of packet n, counted from 0 since the last counter clear, is 64·n modulo the ROM size. Each packet produces exactly 64 ROM writes.
- R7: A `pkt_done` pulse during a burst, but not on its last beat, is latched as pending. The next burst then follows with no idle cycle. Several pulses within one burst count as one pending packet.
- R8: While `dl_mode` is low, `rom_we` is 0 (including writes already in the delay pipeline), `stg_rd_en` is 0 from the next cycle on, and `pkt_done` is ignored.
- R9: The counter is `ROM_AW` bits wide and wraps from 2^ROM_AW−1 to 0. ROM addresses wrap with it.
- R10: A `pkt_done` pulse on the last (64th) beat of a burst starts the next burst in the following cycle, with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dl_mode | input | 1 | Download mode active |
| pkt_done | input | 1 | One-cycle pulse: a 64-byte packet is in the staging RAM |
| stg_rd_en | output | 1 | Staging-RAM read enable |
| stg_rd_addr | output | RAM_AW (8) | Staging-RAM read address |
| stg_rd_data | input | DW (8) | Staging-RAM read data, one cycle after the read |
| rom_we | output | 1 | ROM write enable |
| rom_waddr | output | ROM_AW (10) | ROM write address |
| rom_wdata | output | DW (8) | ROM write data |

## Verification
Two events can fall in the same cycle: the end of a burst and the arrival of the next packet, whether that packet was latched earlier as pending or arrives exactly on the last beat. The bench provokes both cases. It drives a pulse on beat 10 and another on beat 20 of one burst, and a separate pulse on beat 63 of another burst. In each case it expects 128 unbroken read cycles at contiguous addresses, followed by a drop of `stg_rd_en`. A second collision is a download-mode exit in the middle of a burst, with writes still in flight. There the bench expects `rom_we` to fall in the same cycle, a restarted image at address 0, and no reaction to a packet pulse while the mode is low.

// File: rtl/code_loader_pkg.sv
package code_loader_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_COPY = 1'b1
    } cl_state_e;
endpackage

// File: rtl/cl_sequencer.sv
module cl_sequencer
    import code_loader_pkg::*;
#(
    parameter int ROM_AW    = 10,
    parameter int PKT_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_i,
    input  logic              pkt_i,
    output logic              rd_en_o,
    output logic [ROM_AW-1:0] cnt_o
);
    localparam int BW = $clog2(PKT_BYTES);
    localparam logic [BW-1:0] LAST_BEAT = BW'(PKT_BYTES - 1);

    cl_state_e         state, state_nxt;
    logic [BW-1:0]     beat;
    logic [ROM_AW-1:0] cnt;
    logic              pend;
    logic              last_beat;
    logic              more;

    assign last_beat = (state == ST_COPY) && (beat == LAST_BEAT);
    assign more      = pend || pkt_i;

    // next-state decision
    always_comb begin
        state_nxt = state;
        if (!mode_i) begin
            state_nxt = ST_IDLE;                    // abort
        end else begin
            unique case (state)
                ST_IDLE: if (pkt_i) state_nxt = ST_COPY;            // start
                ST_COPY: if (last_beat) state_nxt = more ? ST_COPY  // chain
                                                         : ST_IDLE; // finish
                default: state_nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // counter, beat and pending flag
    always_ff @(posedge clk) begin
        if (!rst_n || !mode_i) begin
            cnt  <= '0;
            beat <= '0;
            pend <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    beat <= '0;
                    pend <= 1'b0;
                end
                ST_COPY: begin
                    cnt  <= cnt + 1'b1;
                    beat <= last_beat ? '0 : beat + 1'b1;
                    if (last_beat)  pend <= 1'b0;
                    else if (pkt_i) pend <= 1'b1;
                end
                default: begin
                    beat <= '0;
                    pend <= 1'b0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        rd_en_o = 1'b0;
        unique case (state)
            ST_IDLE: rd_en_o = 1'b0;
            ST_COPY: rd_en_o = 1'b1;
            default: rd_en_o = 1'b0;
        endcase
        cnt_o = cnt;
    end

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(state == ST_COPY && mode_i) |-> cnt == ROM_AW'($past(cnt) + 1'b1));

    // R2
    burst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_COPY) |-> beat == '0);

    // R8
    mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!mode_i) |-> (cnt == '0 && state == ST_IDLE && !pend));

    // R7
    pend_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(last_beat && pend && mode_i) |-> (state == ST_COPY && beat == '0));

    // R10
    edge_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(last_beat && pkt_i && mode_i) |-> state == ST_COPY);
endmodule

// File: rtl/cl_write_pipe.sv
module cl_write_pipe #(
    parameter int ROM_AW = 10,
    parameter int DW     = 8,
    parameter int RD_LAT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_i,
    input  logic              en_i,
    input  logic [ROM_AW-1:0] addr_i,
    input  logic [DW-1:0]     rd_data_i,
    output logic              we_o,
    output logic [ROM_AW-1:0] addr_o,
    output logic [DW-1:0]     data_o
);
    localparam int DLY = RD_LAT + 1;

    logic              en_q   [DLY];
    logic [ROM_AW-1:0] addr_q [DLY];
    logic [DW-1:0]     data_q;

    for (genvar g = 0; g < DLY; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (!rst_n || !mode_i) begin
                    en_q[0]   <= 1'b0;
                    addr_q[0] <= '0;
                end else begin
                    en_q[0]   <= en_i;
                    addr_q[0] <= addr_i;
                end
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (!rst_n || !mode_i) begin
                    en_q[g]   <= 1'b0;
                    addr_q[g] <= '0;
                end else begin
                    en_q[g]   <= en_q[g-1];
                    addr_q[g] <= addr_q[g-1];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                data_q <= '0;
        else if (en_q[RD_LAT-1])   data_q <= rd_data_i;
    end

    assign we_o   = en_q[DLY-1] && mode_i;
    assign addr_o = addr_q[DLY-1];
    assign data_o = data_q;

    // R4
    we_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |-> $past(en_i, DLY));

    // R4
    addr_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |-> addr_o == $past(addr_i, DLY));

    // R8
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!mode_i) |-> !en_q[DLY-1]);
endmodule

// File: rtl/code_loader.sv
module code_loader #(
    parameter int ROM_AW    = 10,
    parameter int RAM_AW    = 8,
    parameter int DW        = 8,
    parameter int PKT_BYTES = 64,
    parameter int RD_LAT    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dl_mode,
    input  logic              pkt_done,
    output logic              stg_rd_en,
    output logic [RAM_AW-1:0] stg_rd_addr,
    input  logic [DW-1:0]     stg_rd_data,
    output logic              rom_we,
    output logic [ROM_AW-1:0] rom_waddr,
    output logic [DW-1:0]     rom_wdata
);
    logic [ROM_AW-1:0] cnt;
    logic              rd_en;

    cl_sequencer #(
        .ROM_AW    (ROM_AW),
        .PKT_BYTES (PKT_BYTES)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (dl_mode),
        .pkt_i   (pkt_done),
        .rd_en_o (rd_en),
        .cnt_o   (cnt)
    );

    cl_write_pipe #(
        .ROM_AW (ROM_AW),
        .DW     (DW),
        .RD_LAT (RD_LAT)
    ) u_wpipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (dl_mode),
        .en_i      (rd_en),
        .addr_i    (cnt),
        .rd_data_i (stg_rd_data),
        .we_o      (rom_we),
        .addr_o    (rom_waddr),
        .data_o    (rom_wdata)
    );

    assign stg_rd_en   = rd_en;
    assign stg_rd_addr = cnt[RAM_AW-1:0];

    // R8
    no_write_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dl_mode |-> !rom_we);

    // R8
    no_read_after_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!dl_mode) |-> !stg_rd_en);
endmodule

// File: tb/code_loader_tb.sv
module code_loader_tb;
    localparam int ROM_AW = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              dl_mode = 1'b0;
    logic              pkt_done = 1'b0;
    logic              stg_rd_en;
    logic [7:0]        stg_rd_addr;
    logic [7:0]        stg_rd_data = 8'h00;
    logic              rom_we;
    logic [ROM_AW-1:0] rom_waddr;
    logic [7:0]        rom_wdata;

    int n_vec = 0;
    int n_bad = 0;
    int wr_cnt = 0;
    bit done = 1'b0;
    bit mon_on = 1'b0;
    logic [7:0]        exp_ra = 8'h00;
    logic [ROM_AW-1:0] exp_wa = '0;

    always #2.5 clk = ~clk;

    code_loader u_dut (
        .clk(clk), .rst_n(rst_n), .dl_mode(dl_mode), .pkt_done(pkt_done),
        .stg_rd_en(stg_rd_en), .stg_rd_addr(stg_rd_addr), .stg_rd_data(stg_rd_data),
        .rom_we(rom_we), .rom_waddr(rom_waddr), .rom_wdata(rom_wdata)
    );

    function automatic logic [7:0] pat(input logic [7:0] a);
        return 8'((a * 37) + 90);
    endfunction

    // staging RAM model, one-cycle read latency
    always @(posedge clk) if (stg_rd_en) stg_rd_data <= pat(stg_rd_addr);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // write monitor, sampled 2 ns after the active edge
    always @(posedge clk) begin
        #2;
        if (mon_on) begin
            if (!dl_mode) chk(rom_we == 1'b0, "R8 no write in idle mode", int'(rom_we), 0);
            else if (rom_we) begin
                chk(rom_waddr == exp_wa, "R4/R6/R9 rom address", int'(rom_waddr), int'(exp_wa));
                chk(rom_wdata == pat(exp_wa[7:0]), "R5 rom data", int'(rom_wdata), int'(pat(exp_wa[7:0])));
                exp_wa++;
                wr_cnt++;
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // one pulse, then expect 'total' read cycles; extra pulses on beats p1, p2
    task automatic burst(input int total, input int p1, input int p2);
        pkt_done = 1'b1;
        step();
        pkt_done = 1'b0;
        for (int i = 0; i < total; i++) begin
            chk(stg_rd_en == 1'b1, "R2/R7/R10 read enable in burst", int'(stg_rd_en), 1);
            chk(stg_rd_addr == exp_ra, "R3 read address", int'(stg_rd_addr), int'(exp_ra));
            exp_ra++;
            pkt_done = ((i % 64) == p1 || (i % 64) == p2) && (i < 64);
            step();
        end
        pkt_done = 1'b0;
        chk(stg_rd_en == 1'b0, "R2 burst ends", int'(stg_rd_en), 0);
        repeat (3) step();
    endtask

    initial begin
        #(5ns * 150000);
        if (!done) begin
            n_bad++;
            n_vec++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) step();
        chk(stg_rd_en == 1'b0, "R1 reset read enable", int'(stg_rd_en), 0);
        chk(rom_we == 1'b0, "R1 reset write enable", int'(rom_we), 0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        step();
        // R8: pulse while not in download mode is ignored
        pkt_done = 1'b1;
        step();
        pkt_done = 1'b0;
        for (int i = 0; i < 5; i++) begin
            chk(stg_rd_en == 1'b0, "R8 pulse ignored", int'(stg_rd_en), 0);
            step();
        end
        dl_mode = 1'b1;
        repeat (3) step();
        chk(stg_rd_addr == 8'd0, "R1 counter zero", int'(stg_rd_addr), 0);
        // R2, R6: single packets
        for (int k = 0; k < 3; k++) burst(64, -1, -1);
        chk(wr_cnt == 192, "R6 writes per packet", wr_cnt, 192);
        // R7: two pulses during one burst -> one pending packet
        burst(128, 10, 20);
        // R10: pulse on the final beat
        burst(128, 63, -1);
        chk(wr_cnt == 448, "R7/R10 chained write count", wr_cnt, 448);
        // R9: continue past the ROM size
        for (int k = 0; k < 10; k++) burst(64, -1, -1);
        chk(wr_cnt == 1088, "R9 writes across wrap", wr_cnt, 1088);
        chk(exp_wa == ROM_AW'(1088), "R9 wrapped address", int'(exp_wa), 64);
        // R8: exit mid-burst with writes in flight
        pkt_done = 1'b1;
        step();
        pkt_done = 1'b0;
        repeat (20) step();
        dl_mode = 1'b0;
        exp_ra = 8'h00;
        exp_wa = '0;
        #0.5;
        chk(rom_we == 1'b0, "R8 write dropped at exit", int'(rom_we), 0);
        #0.5;
        step();
        pkt_done = 1'b1;
        step();
        pkt_done = 1'b0;
        for (int i = 0; i < 5; i++) begin
            chk(stg_rd_en == 1'b0, "R8 no read in idle mode", int'(stg_rd_en), 0);
            chk(rom_we == 1'b0, "R8 no write in idle mode", int'(rom_we), 0);
            step();
        end
        dl_mode = 1'b1;
        repeat (2) step();
        chk(stg_rd_addr == 8'd0, "R1 counter cleared on exit", int'(stg_rd_addr), 0);
        burst(64, -1, -1);
        chk(exp_wa == ROM_AW'(64), "R1 image restarts at zero", int'(exp_wa), 64);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule